// File: doc/BRIEF.md
# Double-Buffered Clock Register Window

This block is a byte-wide, memory-mapped store that combines a general-purpose RAM with a BCD real-time calendar. The eight highest addresses do not reach RAM cells. Instead they reach a bank of visible clock registers. That bank is kept apart from the internal counters, which advance on a one-second pulse. While neither control bit is set, the visible bank follows the counters on every clock cycle.

Software controls the bank through two bits in the century byte. Setting the halt bit freezes the visible bank so that a multi-byte read is coherent, and the counters keep running underneath. Setting the load bit also freezes the bank, so that a new time can be written into it. Clearing the load bit copies the visible time fields into the counters in one cycle.

Bits of the clock bytes that carry no time field behave as plain RAM. The exception is the top bit of the weekday byte, which always reports a battery-health input. Bus control follows an asynchronous-SRAM convention with active-low select, output enable and write enable, modelled synchronously to the system clock. The address width is a parameter: 15 gives a 32K x 8 space, and the default of 11 gives 2K x 8.

Top module: `clkreg_window`

## Requirements
- R1: After reset the visible bank reads century 0x20, seconds/minutes/hours 0x00, weekday 1, date 0x01, month 0x01, year 0x00, both control bits 0.
- R2: The data-drive enable `dq_oe` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. A write happens on each clock edge with `ce_n`=0 and `we_n`=0.
- R3: Addresses below the top eight store and return full bytes. The top eight map, from offset 0 to 7, to century/control, seconds, minutes, hours, weekday, date, month, year, and writes there never reach the RAM below.
- R4: Each `tick` pulse advances the counters in BCD. The rollovers are seconds 59, minutes 59, hours 23, weekday 7 to 1, date past month length (30 for months 4/6/9/11, 28 or 29 for month 2, otherwise 31), month 12 to 1, year 99 to 00 with a century carry. A year is a leap year when divisible by 4, 00 included.
- R5: While the halt bit (century bit 6) is 1, the visible bank holds its values and ticks still advance the counters.
- R6: With both control bits 0, the visible time fields equal the counters one cycle later. After the halt bit is cleared, every field shows the advanced count by the next clock cycle.
- R7: While the load bit (century bit 7) is 1, the visible bank does not follow the counters. In the cycle after the bit is written to 0, the visible time fields are copied into the counters. A tick in that same cycle advances the copied value by one second.
- R8: Non-time bits keep the values written to them: seconds bit 7, minutes bit 7, hours bits 7:6, weekday bits 6:3, date bits 7:6, month bits 7:5. A write to a clock byte while the bank follows the counters keeps those bits, and the time field comes back to the count one cycle later.
- R9: Weekday bit 7 always reads the `batt_ok` input, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data, zero unless reading |
| dq_oe | output | 1 | Tristate enable for read data |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| batt_ok | input | 1 | Battery-health status |

## Verification
The load of the visible time into the counters and a one-second tick can land in the same cycle. The counters must then apply the increment to the freshly loaded value instead of the old count or dropping the second. The bench provokes this by raising `tick` in the cycle right after the write that clears the load bit. It judges the result by reading the seconds byte two cycles later and expecting the written seconds plus one. A second overlap, a bus write to a clock byte in a cycle where the bank is following the counters, is judged through the spare bits. Those bits must keep the written data while the time field shows the count.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;
  localparam int NUM_CLK  = 8;
  localparam int IDX_CEN  = 0;
  localparam int IDX_SEC  = 1;
  localparam int IDX_MIN  = 2;
  localparam int IDX_HR   = 3;
  localparam int IDX_DAY  = 4;
  localparam int IDX_DATE = 5;
  localparam int IDX_MON  = 6;
  localparam int IDX_YR   = 7;
  localparam int BIT_LOAD = 7;
  localparam int BIT_HALT = 6;
  localparam int BIT_BATT = 7;

  typedef logic [7:0] byte_t;
  typedef byte_t [NUM_CLK-1:0] clk_bank_t;

  // bits of each clock byte that belong to the time field
  function automatic byte_t time_mask(input int idx);
    case (idx)
      IDX_CEN:  return 8'h3F;
      IDX_SEC:  return 8'h7F;
      IDX_MIN:  return 8'h7F;
      IDX_HR:   return 8'h3F;
      IDX_DAY:  return 8'h07;
      IDX_DATE: return 8'h3F;
      IDX_MON:  return 8'h1F;
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic byte_t reset_value(input int idx);
    case (idx)
      IDX_CEN:  return 8'h20;
      IDX_DAY:  return 8'h01;
      IDX_DATE: return 8'h01;
      IDX_MON:  return 8'h01;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic byte_t bcd_inc(input byte_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(input byte_t yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic byte_t month_last(input byte_t mon, input byte_t yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/clkreg_counter.sv
module clkreg_counter
  import clkreg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  clk_bank_t load_val,
  output clk_bank_t cnt_q
);
  clk_bank_t cnt_d;
  logic      cnt_en;

  assign cnt_en = tick | load;

  always_comb begin : p_next
    clk_bank_t src;
    logic      cy;
    for (int i = 0; i < NUM_CLK; i++)
      src[i] = load ? (load_val[i] & time_mask(i)) : cnt_q[i];
    cnt_d = src;
    cy    = tick;
    if (cy) begin
      if (src[IDX_SEC] == 8'h59) cnt_d[IDX_SEC] = 8'h00;
      else begin cnt_d[IDX_SEC] = bcd_inc(src[IDX_SEC]); cy = 1'b0; end
    end
    if (cy) begin
      if (src[IDX_MIN] == 8'h59) cnt_d[IDX_MIN] = 8'h00;
      else begin cnt_d[IDX_MIN] = bcd_inc(src[IDX_MIN]); cy = 1'b0; end
    end
    if (cy) begin
      if (src[IDX_HR] == 8'h23) cnt_d[IDX_HR] = 8'h00;
      else begin cnt_d[IDX_HR] = bcd_inc(src[IDX_HR]); cy = 1'b0; end
    end
    if (cy)
      cnt_d[IDX_DAY] = (src[IDX_DAY] == 8'h07) ? 8'h01 : bcd_inc(src[IDX_DAY]);
    if (cy) begin
      if (src[IDX_DATE] == month_last(src[IDX_MON], src[IDX_YR])) cnt_d[IDX_DATE] = 8'h01;
      else begin cnt_d[IDX_DATE] = bcd_inc(src[IDX_DATE]); cy = 1'b0; end
    end
    if (cy) begin
      if (src[IDX_MON] == 8'h12) cnt_d[IDX_MON] = 8'h01;
      else begin cnt_d[IDX_MON] = bcd_inc(src[IDX_MON]); cy = 1'b0; end
    end
    if (cy) begin
      if (src[IDX_YR] == 8'h99) cnt_d[IDX_YR] = 8'h00;
      else begin cnt_d[IDX_YR] = bcd_inc(src[IDX_YR]); cy = 1'b0; end
    end
    if (cy)
      cnt_d[IDX_CEN] = (src[IDX_CEN] == 8'h39) ? 8'h00 : bcd_inc(src[IDX_CEN]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CLK; i++) cnt_q[i] <= reset_value(i);
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/clkreg_holding.sv
module clkreg_holding
  import clkreg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit,
  input  logic [2:0] wr_idx,
  input  byte_t     wr_data,
  input  clk_bank_t cnt_q,
  output clk_bank_t vis_q,
  output logic      load
);
  logic halt, load_bit, load_bit_prev_q, track;

  assign halt     = vis_q[IDX_CEN][BIT_HALT];
  assign load_bit = vis_q[IDX_CEN][BIT_LOAD];
  assign load     = load_bit_prev_q & ~load_bit;
  assign track    = ~halt & ~load_bit & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_bit_prev_q <= 1'b0;
    else        load_bit_prev_q <= load_bit;
  end

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_byte
    localparam byte_t TMASK = time_mask(i);
    localparam byte_t SMASK = (i == IDX_DAY) ? ~(8'h01 << BIT_BATT) : 8'hFF;
    byte_t byte_q, byte_d;
    logic  hit, en;

    assign hit = wr_hit && (wr_idx == 3'(i));
    assign en  = hit | track;

    always_comb begin
      if (hit) byte_d = wr_data & SMASK;
      else     byte_d = (byte_q & ~TMASK) | (cnt_q[i] & TMASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  byte_q <= reset_value(i);
      else if (en) byte_q <= byte_d;
    end

    assign vis_q[i] = byte_q;
  end
endmodule

// File: rtl/clkreg_window.sv
module clkreg_window
  import clkreg_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  input  logic              tick,
  input  logic              batt_ok
);
  localparam int DEPTH = 1 << ADDR_W;

  logic      rst_meta_q, rst_sync_n;
  logic      win_hit, bus_wr, bus_rd, win_wr, ram_we;
  logic [2:0] idx;
  clk_bank_t cnt_q, vis_q;
  logic      load;
  byte_t     clk_byte, ram_byte;
  byte_t     mem [DEPTH];

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign win_hit = &addr[ADDR_W-1:3];
  assign idx     = addr[2:0];
  assign bus_wr  = ~ce_n & ~we_n;
  assign bus_rd  = ~ce_n & ~oe_n & we_n;
  assign win_wr  = bus_wr & win_hit;
  assign ram_we  = bus_wr & ~win_hit;

  always_ff @(posedge clk) begin
    if (ram_we) mem[addr] <= dq_in;
  end

  clkreg_counter u_counter (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .load(load),
    .load_val(vis_q), .cnt_q(cnt_q)
  );

  clkreg_holding u_holding (
    .clk(clk), .rst_n(rst_sync_n), .wr_hit(win_wr), .wr_idx(idx),
    .wr_data(dq_in), .cnt_q(cnt_q), .vis_q(vis_q), .load(load)
  );

  always_comb begin
    clk_byte = vis_q[idx];
    if (idx == 3'(IDX_DAY)) clk_byte[BIT_BATT] = batt_ok;
    ram_byte = mem[addr];
  end

  assign dq_oe  = bus_rd;
  assign dq_out = bus_rd ? (win_hit ? clk_byte : ram_byte) : 8'h00;
endmodule

// File: rtl/clkreg_window_chk.sv
module clkreg_window_chk
  import clkreg_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dq_out,
  input logic              dq_oe,
  input logic              batt_ok,
  input logic              tick,
  input logic              load,
  input logic              win_wr,
  input clk_bank_t         vis_q,
  input clk_bank_t         cnt_q
);
  localparam logic [ADDR_W-1:0] DAY_ADDR = {{(ADDR_W-3){1'b1}}, 3'd4};

  assert_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> !dq_oe);

  assert_batt_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && addr == DAY_ADDR) |-> (dq_out[BIT_BATT] == batt_ok));

  assert_halt_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vis_q[IDX_CEN][BIT_HALT] && $past(vis_q[IDX_CEN][BIT_HALT]) && !$past(win_wr))
      |-> (vis_q == $past(vis_q)));

  assert_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!vis_q[IDX_CEN][BIT_HALT] && !vis_q[IDX_CEN][BIT_LOAD] && !load && !win_wr)
      |-> ((vis_q[IDX_SEC] & 8'h7F) == $past(cnt_q[IDX_SEC])));

  assert_load_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load) && !$past(tick)) |-> (cnt_q[IDX_SEC] == ($past(vis_q[IDX_SEC]) & 8'h7F)));
endmodule

bind clkreg_window clkreg_window_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe), .batt_ok(batt_ok),
  .tick(tick), .load(load), .win_wr(win_wr), .vis_q(vis_q), .cnt_q(cnt_q)
);

// File: tb/clkreg_window_tb_top.sv
module clkreg_window_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 11;
  localparam logic [ADDR_W-1:0] WIN = 11'h7F8;

  logic clk, rst_n, ce_n, oe_n, we_n, tick, batt_ok, dq_oe;
  logic [ADDR_W-1:0] addr;
  logic [7:0] dq_in, dq_out;
  int n_run, n_fail;
  bit done;

  clkreg_window #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .tick(tick), .batt_ok(batt_ok)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int month_days(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1 d = dq_out;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] cen, yr, mon, dt, dy, hr, mn, sc);
    bus_write(WIN + 0, 8'h80 | cen);
    bus_write(WIN + 1, sc);  bus_write(WIN + 2, mn);  bus_write(WIN + 3, hr);
    bus_write(WIN + 4, dy);  bus_write(WIN + 5, dt);  bus_write(WIN + 6, mon);
    bus_write(WIN + 7, yr);
    bus_write(WIN + 0, cen);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; tick = 1'b0;
    batt_ok = 1'b1; addr = '0; dq_in = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(WIN + 0, d); check("R1 century", d, 8'h20);
    bus_read(WIN + 1, d); check("R1 seconds", d, 8'h00);
    bus_read(WIN + 3, d); check("R1 hours", d, 8'h00);
    bus_read(WIN + 4, d); check("R1 weekday", d, 8'h81);
    bus_read(WIN + 5, d); check("R1 date", d, 8'h01);
    bus_read(WIN + 6, d); check("R1 month", d, 8'h01);
    bus_read(WIN + 7, d); check("R1 year", d, 8'h00);

    // R2 every control combination
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      addr = 11'h005; dq_in = 8'h5A;
      ce_n = c[2]; oe_n = c[1]; we_n = c[0];
      #1 check("R2 dq_oe", {7'd0, dq_oe}, {7'd0, (c == 1)});
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    end

    // R3 RAM sweep below the window
    for (int a = 0; a < 'h7F8; a += 9) bus_write(ADDR_W'(a), 8'(a) ^ 8'(a >> 3));
    bus_write(11'h7F7, 8'hC3);
    for (int a = 0; a < 'h7F8; a += 9) begin
      bus_read(ADDR_W'(a), d); check("R3 ram", d, 8'(a) ^ 8'(a >> 3));
    end

    // R4 seconds/minutes sweep
    set_time(8'h20, 8'h23, 8'h05, 8'h10, 8'h03, 8'h08, 8'h00, 8'h00);
    for (int n = 1; n <= 130; n++) begin
      do_tick();
      bus_read(WIN + 1, d); check("R4 seconds", d, to_bcd(n % 60));
      bus_read(WIN + 2, d); check("R4 minutes", d, to_bcd(n / 60));
    end

    // R4 end of every month, common and leap year
    for (int y = 23; y <= 24; y++) begin
      for (int m = 1; m <= 12; m++) begin
        set_time(8'h20, to_bcd(y), to_bcd(m), to_bcd(month_days(m, y)), 8'h07,
                 8'h23, 8'h59, 8'h59);
        do_tick();
        bus_read(WIN + 5, d); check("R4 date wrap", d & 8'h3F, 8'h01);
        bus_read(WIN + 6, d); check("R4 month", d & 8'h1F, to_bcd(m == 12 ? 1 : m + 1));
        bus_read(WIN + 7, d); check("R4 year", d, to_bcd(m == 12 ? y + 1 : y));
        bus_read(WIN + 4, d); check("R4 weekday wrap", d & 8'h07, 8'h01);
        bus_read(WIN + 3, d); check("R4 hours wrap", d & 8'h3F, 8'h00);
      end
    end

    // R4 century carry, and year 00 counted as leap
    set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    do_tick();
    bus_read(WIN + 7, d); check("R4 year 99 wrap", d, 8'h00);
    bus_read(WIN + 0, d); check("R4 century carry", d, 8'h21);
    bus_read(WIN + 4, d); check("R4 weekday", d & 8'h07, 8'h03);
    set_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    do_tick();
    bus_read(WIN + 5, d); check("R4 leap 00", d & 8'h3F, 8'h29);

    // R5 halt freezes, R6 refresh after release
    set_time(8'h20, 8'h24, 8'h06, 8'h15, 8'h05, 8'h12, 8'h30, 8'h10);
    bus_write(WIN + 0, 8'h60);
    for (int k = 0; k < 3; k++) do_tick();
    bus_read(WIN + 1, d); check("R5 frozen seconds", d, 8'h10);
    bus_read(WIN + 0, d); check("R5 halt bit", d, 8'h60);
    bus_write(WIN + 0, 8'h20);
    bus_read(WIN + 1, d); check("R6 refreshed seconds", d, 8'h13);
    bus_read(WIN + 2, d); check("R6 minutes", d, 8'h30);

    // R7 load bit freezes; load and tick in the same cycle
    bus_write(WIN + 0, 8'hA0);
    do_tick();
    bus_read(WIN + 1, d); check("R7 frozen under load bit", d, 8'h13);
    bus_write(WIN + 1, 8'h45);
    bus_write(WIN + 0, 8'h20);
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    bus_read(WIN + 1, d); check("R7 load plus tick", d, 8'h46);
    bus_read(WIN + 2, d); check("R7 loaded minutes", d, 8'h30);

    // R8 spare bits behave as RAM while tracking
    bus_write(WIN + 1, 8'h80);
    bus_read(WIN + 1, d); check("R8 seconds spare", d, 8'hC6);
    bus_write(WIN + 3, 8'hC0);
    bus_read(WIN + 3, d); check("R8 hours spare", d, 8'hD2);
    bus_write(WIN + 6, 8'hE0);
    bus_read(WIN + 6, d); check("R8 month spare", d, 8'hE6);
    do_tick();
    bus_read(WIN + 1, d); check("R8 spare kept after tick", d, 8'hC7);

    // R9 battery flag follows input, writes ignored
    bus_write(WIN + 4, 8'hFF);
    bus_read(WIN + 4, d); check("R9 flag high, spare written", d, 8'hFD);
    batt_ok = 1'b0;
    bus_read(WIN + 4, d); check("R9 flag low", d, 8'h7D);
    bus_write(WIN + 4, 8'h80);
    bus_read(WIN + 4, d); check("R9 write ignored", d, 8'h05);
    batt_ok = 1'b1;

    // R3 RAM below window untouched by clock writes
    bus_read(11'h7F7, d); check("R3 ram below window", d, 8'hC3);

    done = 1'b1;
    summary();
  end
endmodule